// File: doc/BRIEF.md
# Sixteen-Bit Single-Cycle Load/Store Core

This block is a small processor core that retires one instruction per clock. The core holds its own program counter, instruction decoder, ALU, eight general registers and a 128-word data RAM. Instruction storage is outside the core. The core puts the program counter on `imem_addr`, and the surrounding logic must return the addressed instruction on `imem_data` within the same cycle.

Every instruction is one 16-bit word. The three top bits select the class: register-register (0), reserved (1), jump (2), jump-and-link (3), load (4), store (5), branch-if-equal (6) and add-immediate (7). For a register-register word, the fields run as follows: source A at [12:10], source B at [9:7], destination at [6:4] and function at [3:0]. Immediate words use the same two source positions and carry a signed 7-bit constant in [6:0]. Jump words carry a 13-bit word target in [12:0]. The two ALU operands and the ALU result are driven on output ports, so a bench or a debug monitor can follow execution without access to the internals.

Top module: `tiny16_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter becomes 0 and all eight registers become 0.
- R2: Every instruction that is not a jump, a jr or a taken branch advances `imem_addr` by exactly 2.
- R3: With class 0, function codes 0, 1, 2, 3 and 4 write A+B, A-B, A&B, A|B and the signed A<B (1 or 0) into the destination field's register.
- R4: Register 0 always reads as zero. A write aimed at it is discarded.
- R5: add-immediate (class 7) sign-extends bits [6:0] to 16 bits, adds the result to source A and writes the sum into the register in [9:7].
- R6: Load (class 4) and store (class 5) use the byte address A + sign-extended [6:0]. Bits [7:1] of that address select one of 128 words, so bit 0 is ignored and addresses wrap every 256 bytes. A load writes the word into the register in [9:7]. A store writes that register's value into RAM and changes no register.
- R7: branch (class 6) compares source A with source B. When they are equal, the next PC is PC+2 plus twice the sign-extended [6:0]. Otherwise it is PC+2.
- R8: jump (class 2) sets the PC to {(PC+2)[15:14], [12:0], 0}.
- R9: jump-and-link (class 3) jumps as in R8 and also writes PC+2 into register 7.
- R10: Class 0 with function 8 (jr) loads the PC from source A and writes no register.
- R11: `alu_a` carries the source A register. `alu_b` carries the source B register for class 0 and class 6, and the sign-extended immediate for classes 4, 5 and 7. `alu_y` carries the ALU result, which is the sum for loads, stores and add-immediate and A-B for branches.
- R12: The reserved class 1, and class 0 with a function code outside {0,1,2,3,4,8}, write no register and no RAM word, and advance the PC by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 16 | Byte address of the current instruction (the PC) |
| imem_data | input | 16 | Instruction word at `imem_addr`, returned combinationally |
| alu_a | output | 16 | First ALU operand |
| alu_b | output | 16 | Second ALU operand |
| alu_y | output | 16 | ALU result |

## Verification
Bad register or RAM contents do not show up until a later instruction reads them. The bench therefore follows each write with an instruction that routes the written location onto `alu_a` or `alu_b`, so a wrong value appears at the ports one cycle after the write. A wrong next-PC choice shows on `imem_addr` in the very next cycle. The bench keeps its own instruction-level model of registers, RAM and PC and compares against it on every instruction. It sweeps operand pairs over the signed range for all five ALU functions, covers every RAM word including address wrap, and exercises branch offsets in both directions and jump targets across the upper PC bits.

// File: rtl/tiny16_pkg.sv
// Package: ISA constants and decoded-control types for the 16-bit core.
// Assumes the fixed 16-bit instruction layout described in the brief.
package tiny16_pkg;

    localparam int XLEN   = 16;
    localparam int NREG   = 8;
    localparam int REG_AW = $clog2(NREG);
    localparam int IMM_W  = 7;
    localparam int TGT_W  = 13;
    localparam int LINK_R = NREG - 1;

    localparam logic [2:0] OP_RRR  = 3'd0;
    localparam logic [2:0] OP_J    = 3'd2;
    localparam logic [2:0] OP_JAL  = 3'd3;
    localparam logic [2:0] OP_LD   = 3'd4;
    localparam logic [2:0] OP_ST   = 3'd5;
    localparam logic [2:0] OP_BEQ  = 3'd6;
    localparam logic [2:0] OP_ADDI = 3'd7;

    localparam logic [3:0] FN_ADD = 4'd0;
    localparam logic [3:0] FN_SUB = 4'd1;
    localparam logic [3:0] FN_AND = 4'd2;
    localparam logic [3:0] FN_OR  = 4'd3;
    localparam logic [3:0] FN_SLT = 4'd4;
    localparam logic [3:0] FN_JR  = 4'd8;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_fn_e;

    typedef enum logic [1:0] {
        DST_RD, DST_RT, DST_LINK
    } dst_e;

    typedef enum logic [1:0] {
        WB_ALU, WB_MEM, WB_LINK
    } wb_e;

    typedef struct packed {
        logic    reg_we;
        dst_e    dst;
        logic    use_imm;
        logic    mem_we;
        wb_e     wb;
        alu_fn_e alu;
        logic    branch;
        logic    jump;
        logic    jreg;
    } ctrl_t;

endpackage

// File: rtl/tiny16_ctrl.sv
// Instruction decoder: maps the class and function fields to datapath controls.
// Purely combinational. Unknown classes and functions decode to a harmless
// no-write, sequential-PC instruction.
module tiny16_ctrl
    import tiny16_pkg::*;
(
    input  logic [2:0] op,
    input  logic [3:0] funct,
    output ctrl_t      ctl
);

    // Translate a class-0 function code into an ALU operation.
    function automatic alu_fn_e fn_to_alu(input logic [3:0] f);
        case (f)
            FN_SUB:  return ALU_SUB;
            FN_AND:  return ALU_AND;
            FN_OR:   return ALU_OR;
            FN_SLT:  return ALU_SLT;
            default: return ALU_ADD;
        endcase
    endfunction

    // Main decode: start from a no-op and enable only what each class needs.
    always_comb begin
        ctl         = '0;
        ctl.dst     = DST_RD;
        ctl.wb      = WB_ALU;
        ctl.alu     = ALU_ADD;
        case (op)
            OP_RRR: begin
                ctl.alu = fn_to_alu(funct);
                if (funct == FN_JR)
                    ctl.jreg = 1'b1;
                else if (funct <= FN_SLT)
                    ctl.reg_we = 1'b1;
            end
            OP_J: ctl.jump = 1'b1;
            OP_JAL: begin
                ctl.jump   = 1'b1;
                ctl.reg_we = 1'b1;
                ctl.dst    = DST_LINK;
                ctl.wb     = WB_LINK;
            end
            OP_LD: begin
                ctl.reg_we  = 1'b1;
                ctl.dst     = DST_RT;
                ctl.use_imm = 1'b1;
                ctl.wb      = WB_MEM;
            end
            OP_ST: begin
                ctl.use_imm = 1'b1;
                ctl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctl.alu    = ALU_SUB;
                ctl.branch = 1'b1;
            end
            OP_ADDI: begin
                ctl.reg_we  = 1'b1;
                ctl.dst     = DST_RT;
                ctl.use_imm = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tiny16_alu.sv
// ALU: add, subtract, and, or, signed set-less-than, plus a zero flag.
// Combinational; W bits wide.
module tiny16_alu
    import tiny16_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_fn_e      fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);

    // Select the operation result.
    always_comb begin
        case (fn)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/tiny16_regs.sv
// Register file: NREGS x W, two combinational read ports, one write port.
// Entry 0 is never written. Synchronous active-low reset clears every entry.
module tiny16_regs #(
    parameter int W     = 16,
    parameter int NREGS = 8,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [NREGS];

    // Clear on reset; otherwise commit one write, never to entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

    // R4: the zero register never holds anything but zero.
    p_zero_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        regs[0] == '0);

    // R3: an enabled write to a non-zero entry is visible on the next cycle.
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> regs[$past(wa)] == $past(wd));

endmodule

// File: rtl/tiny16_dram.sv
// Data RAM: DEPTH words, combinational read, write on the rising edge.
// Word index is the byte address bits [IW:1]; bit 0 is ignored. No reset.
module tiny16_dram #(
    parameter int W     = 16,
    parameter int DEPTH = 128,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] addr,
    input  logic         we,
    input  logic [W-1:0] wd,
    output logic [W-1:0] rd
);

    logic [W-1:0]  mem [DEPTH];
    logic [IW-1:0] idx;

    assign idx = addr[IW:1];
    assign rd  = mem[idx];

    // Store one word per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wd;
    end

    // R6: a store is readable at its word index on the following cycle.
    p_store_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(idx)] == $past(wd));

endmodule

// File: rtl/tiny16_core.sv
// Single-cycle core: PC, decode, register file, ALU, data RAM and next-PC
// selection. Assumes imem_data returns the word at imem_addr in the same cycle.
module tiny16_core
    import tiny16_pkg::*;
#(
    parameter int RAM_WORDS = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] alu_a,
    output logic [XLEN-1:0] alu_b,
    output logic [XLEN-1:0] alu_y
);

    localparam int HI_W = XLEN - TGT_W - 1;

    logic [XLEN-1:0]   pc_q, pc_next, pc_plus2, br_tgt, jmp_tgt;
    logic [2:0]        op;
    logic [REG_AW-1:0] rs, rt, rd, wa;
    logic [3:0]        funct;
    logic [IMM_W-1:0]  imm;
    logic [TGT_W-1:0]  tgt;
    logic [XLEN-1:0]   simm, rs_val, rt_val, mem_rd, wdata;
    logic              alu_zero;
    ctrl_t             ctl;

    // Field extraction.
    assign op    = imem_data[15:13];
    assign rs    = imem_data[12:10];
    assign rt    = imem_data[9:7];
    assign rd    = imem_data[6:4];
    assign funct = imem_data[3:0];
    assign imm   = imem_data[IMM_W-1:0];
    assign tgt   = imem_data[TGT_W-1:0];
    assign simm  = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

    tiny16_ctrl u_ctrl (
        .op    (op),
        .funct (funct),
        .ctl   (ctl)
    );

    tiny16_regs #(.W(XLEN), .NREGS(NREG)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (rs),
        .ra2   (rt),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .we    (ctl.reg_we),
        .wa    (wa),
        .wd    (wdata)
    );

    assign alu_a = rs_val;
    assign alu_b = ctl.use_imm ? simm : rt_val;

    tiny16_alu #(.W(XLEN)) u_alu (
        .fn   (ctl.alu),
        .a    (alu_a),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    tiny16_dram #(.W(XLEN), .DEPTH(RAM_WORDS)) u_dram (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (alu_y),
        .we    (ctl.mem_we),
        .wd    (rt_val),
        .rd    (mem_rd)
    );

    // Destination register and write-back value selection.
    always_comb begin
        case (ctl.dst)
            DST_RT:   wa = rt;
            DST_LINK: wa = REG_AW'(LINK_R);
            default:  wa = rd;
        endcase
        case (ctl.wb)
            WB_MEM:  wdata = mem_rd;
            WB_LINK: wdata = pc_plus2;
            default: wdata = alu_y;
        endcase
    end

    assign pc_plus2 = pc_q + XLEN'(2);
    assign br_tgt   = pc_plus2 + {simm[XLEN-2:0], 1'b0};
    assign jmp_tgt  = {pc_plus2[XLEN-1 -: HI_W], tgt, 1'b0};

    // Next-PC priority: register jump, direct jump, taken branch, sequential.
    always_comb begin
        if (ctl.jreg)                    pc_next = rs_val;
        else if (ctl.jump)               pc_next = jmp_tgt;
        else if (ctl.branch && alu_zero) pc_next = br_tgt;
        else                             pc_next = pc_plus2;
    end

    // Program counter register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign imem_addr = pc_q;

    // R2: straight-line instructions step the PC by one word.
    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.jreg && !ctl.jump && !ctl.branch) |=> pc_q == $past(pc_q) + 16'd2);

    // R7: an equal compare redirects to the branch target.
    p_beq_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.branch && rs_val == rt_val) |=> pc_q == $past(br_tgt));

    // R7: an unequal compare falls through.
    p_beq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.branch && rs_val != rt_val) |=> pc_q == $past(pc_q) + 16'd2);

    // R10: jr takes the PC from source A.
    p_jr_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.jreg |=> pc_q == $past(rs_val));

    // R12: register writes and stores never occur together.
    p_one_sink_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.reg_we && ctl.mem_we));

endmodule

// File: tb/tiny16_core_tb.sv
// Bench: acts as instruction memory, keeps an instruction-level reference
// model and checks PC and ALU ports on every instruction.
module tiny16_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] imem_data = 16'h0000;
    wire  [15:0] imem_addr, alu_a, alu_b, alu_y;

    always #4 clk = ~clk;

    tiny16_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .alu_a     (alu_a),
        .alu_b     (alu_b),
        .alu_y     (alu_y)
    );

    int          total = 0;
    int          bad = 0;
    logic [15:0] rf  [8];
    logic [15:0] ram [128];
    logic [15:0] pc;

    function automatic logic [15:0] enc_r(int s, int t, int d, int f);
        return {3'd0, 3'(s), 3'(t), 3'(d), 4'(f)};
    endfunction

    function automatic logic [15:0] enc_i(int op, int s, int t, int im);
        return {3'(op), 3'(s), 3'(t), 7'(im)};
    endfunction

    function automatic logic [15:0] enc_j(int op, int tg);
        return {3'(op), 13'(tg)};
    endfunction

    function automatic logic [15:0] sx7(logic [6:0] v);
        return {{9{v[6]}}, v};
    endfunction

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Enter just after a falling edge; drive one instruction, check, advance.
    task automatic run(input logic [15:0] ins, input string tag);
        logic [2:0]  op;
        logic [2:0]  s, t, d;
        logic [3:0]  f;
        logic [15:0] a, b, y, pc2, npc, si;
        logic        has_y;
        op = ins[15:13]; s = ins[12:10]; t = ins[9:7]; d = ins[6:4];
        f = ins[3:0]; si = sx7(ins[6:0]);
        imem_data = ins;
        #1;
        chk(tag, "pc", imem_addr, pc);
        a = rf[s];
        b = (op == 3'd4 || op == 3'd5 || op == 3'd7) ? si : rf[t];
        has_y = 1'b1;
        y = '0;
        case (op)
            3'd0: case (f)
                4'd0: y = a + b;
                4'd1: y = a - b;
                4'd2: y = a & b;
                4'd3: y = a | b;
                4'd4: y = ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
                default: has_y = 1'b0;
            endcase
            3'd4, 3'd5, 3'd7: y = a + b;
            3'd6: y = a - b;
            default: has_y = 1'b0;
        endcase
        if (has_y) begin
            chk("R11", "alu_a", alu_a, a);
            chk("R11", "alu_b", alu_b, b);
            chk(tag, "alu_y", alu_y, y);
        end
        pc2 = pc + 16'd2;
        npc = pc2;
        case (op)
            3'd0: if (f == 4'd8) npc = a;
                  else if (f <= 4'd4) rf[d] = y;
            3'd2: npc = {pc2[15:14], ins[12:0], 1'b0};
            3'd3: begin npc = {pc2[15:14], ins[12:0], 1'b0}; rf[7] = pc2; end
            3'd4: rf[t] = ram[y[7:1]];
            3'd5: ram[y[7:1]] = rf[t];
            3'd6: if (a == rf[t]) npc = pc2 + {si[14:0], 1'b0};
            3'd7: rf[t] = y;
            default: ;
        endcase
        rf[0] = '0;
        pc = npc;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        imem_data = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pc = '0;
        for (int i = 0; i < 8; i++) rf[i] = '0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        // R1: PC and every register start at zero.
        for (int k = 1; k < 8; k++) run(enc_r(k, 0, 0, 0), "R1");

        // R3 / R5 sweep over operand pairs, widened by doubling.
        for (int i = 0; i < 15; i++) begin
            for (int j = 0; j < 15; j++) begin
                run(enc_i(7, 0, 1, -64 + 9 * i), "R5");
                run(enc_i(7, 0, 2, -64 + 9 * j), "R5");
                for (int k = 0; k < i % 5; k++) run(enc_r(1, 1, 1, 0), "R3");
                for (int k = 0; k < j % 3; k++) run(enc_r(2, 2, 2, 0), "R3");
                run(enc_r(1, 2, 3, 0), "R3");
                run(enc_r(1, 2, 4, 1), "R3");
                run(enc_r(1, 2, 5, 2), "R3");
                run(enc_r(1, 2, 6, 3), "R3");
                run(enc_r(1, 2, 3, 4), "R3");
                run(enc_r(2, 1, 4, 4), "R3");
                run(enc_r(3, 4, 0, 0), "R3");
            end
        end

        // R4: writes to register 0 vanish.
        run(enc_i(7, 0, 0, 5), "R4");
        run(enc_r(1, 2, 0, 0), "R4");
        run(enc_r(0, 0, 1, 0), "R4");
        run(enc_r(0, 0, 0, 0), "R4");

        // R6: fill every RAM word, then read them back.
        run(enc_i(7, 0, 1, 0), "R6");
        for (int i = 0; i < 128; i++) begin
            run(enc_i(7, 0, 2, (i * 37) % 128 - 64), "R6");
            run(enc_r(2, 1, 2, 0), "R6");
            run(enc_i(5, 1, 2, 0), "R6");
            run(enc_i(7, 1, 1, 2), "R6");
        end
        run(enc_i(4, 1, 3, 0), "R6");          // byte address 256 wraps to word 0
        run(enc_r(3, 0, 0, 0), "R6");
        run(enc_i(7, 0, 1, 0), "R6");
        for (int i = 0; i < 128; i++) begin
            run(enc_i(4, 1, 3, 0), "R6");
            run(enc_r(3, 0, 0, 0), "R6");
            run(enc_i(7, 1, 1, 2), "R6");
        end
        run(enc_i(7, 0, 1, 10), "R6");
        run(enc_i(4, 1, 3, -2), "R6");         // negative offset, word 4
        run(enc_r(3, 0, 0, 0), "R6");
        run(enc_i(4, 0, 3, 1), "R6");          // odd byte address, word 0
        run(enc_r(3, 0, 0, 0), "R6");

        // R7: taken forward, taken backward, not taken, offset sweep.
        run(enc_i(7, 0, 1, 5), "R7");
        run(enc_i(7, 0, 2, 5), "R7");
        run(enc_i(6, 1, 2, 3), "R7");
        run(enc_i(6, 1, 2, -4), "R7");
        run(enc_i(7, 0, 2, 6), "R7");
        run(enc_i(6, 1, 2, 10), "R7");
        run(enc_i(6, 0, 0, -1), "R7");
        for (int o = -64; o < 64; o += 7) run(enc_i(6, 0, 0, o), "R7");

        // R10: register jumps.
        run(enc_i(7, 0, 4, 40), "R10");
        run(enc_r(4, 0, 5, 8), "R10");
        run(enc_r(5, 0, 0, 0), "R10");
        run(enc_r(0, 0, 0, 8), "R10");
        run(enc_i(7, 0, 1, -64), "R10");
        run(enc_r(1, 0, 0, 8), "R10");         // PC = 0xFFC0

        // R8: jumps keep the upper PC+2 bits.
        run(enc_j(2, 13'h1234), "R8");
        for (int k = 0; k < 20; k++) run(enc_j(2, (k * 397) % 8192), "R8");

        // R9: jump-and-link, then show register 7.
        for (int k = 0; k < 6; k++) begin
            run(enc_j(3, (k * 1111) % 8192), "R9");
            run(enc_r(7, 0, 0, 0), "R9");
        end

        // R12: reserved class and unused functions do nothing.
        run(enc_i(7, 0, 1, 21), "R12");
        run({3'd1, 13'h1FFF}, "R12");
        for (int f = 5; f < 16; f++) if (f != 8) run(enc_r(0, 0, 1, f), "R12");
        run(enc_r(1, 0, 0, 0), "R12");

        // R1: reset mid-run clears PC and registers again.
        run(enc_i(7, 0, 6, 33), "R1");
        do_reset();
        for (int k = 1; k < 8; k++) run(enc_r(k, 0, 0, 0), "R1");

        summary();
        $finish;
    end

endmodule